// File: doc/BRIEF.md
# Daisy-Chained DMA Bus Arbiter

This block shares one memory write port among several DMA devices. Every device drives a request, and the requests are ORed into a single line. When the memory port can accept a word and at least one device is asking, the controller starts a grant at the head of a chain of per-device cells. Each cell either keeps the grant for its own device or hands it to the next cell. The device that keeps the grant gives up one word, made of an address and data, in that cycle. The controller holds that word on the memory port until the memory reports that the cycle is complete. A device needs nothing more than its request and the acknowledge that comes back. There is no master/slave setup with the memory.

Position in the chain sets priority, and index 0 sits next to the controller. A device that has just been served passes the next grant down the chain while any device further down is still asking. Requesters that stay asserted are therefore served in ascending index order, one word per memory cycle, and the pattern starts again from the top. A device that drops its request and raises it again loses its skip state. It then wins at the next grant, ahead of the devices the scan has not yet reached. The grant for the next word is issued in the same cycle that the memory completes the current one, so a stream of requests keeps the port busy with no idle cycles in between.

Device side and memory side are both valid/ready. On the device side, `dev_valid[i]` is the request, and `dev_addr` and `dev_data` must stay steady while it is high. `dev_ready[i]` is high for exactly the cycle in which the word is taken. On the memory side, `mem_valid` and its payload stay stable until `mem_ready` is high on a rising edge. While the memory holds `mem_ready` low, every device is held off.

Top module: `dca_arbiter`

## Requirements
- R1: During reset and after it, with no requests, `mem_valid` and every `dev_ready` bit are low.
- R2: At most one `dev_ready` bit is high in any cycle. Exactly one is high, and it belongs to a requesting device, whenever some `dev_valid` bit is high and the port is open. The port is open when `mem_valid` is low or `mem_ready` is high.
- R3: When no device carries skip state (for example after all requests were low for a cycle), the requesting device with the lowest index wins the grant.
- R4: When `dev_ready[i]` is high on an edge, then from the next cycle `mem_valid` is high, `mem_addr` and `mem_data` equal device i's slice (bits `i*ADDR_W` and `i*DATA_W` upward), and `mem_src` equals i.
- R5: A device that was served, and stays requesting, passes the next grant on while a higher-index device is requesting. With a constant set of requesters, grants go through the set bits in ascending order and then start again from the lowest one.
- R6: A device whose `dev_valid` was low in the previous cycle and is high now wins the grant over every higher-index requester, even when those requesters are further along in the current pass.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_src` stay stable and no `dev_ready` bit is raised.
- R8: In a cycle where `mem_ready` completes a word and some device is requesting, the next grant is given in that same cycle, with no idle cycle between words.
- R9: With no device requesting, no `dev_ready` bit is raised, and `mem_valid` goes low on the cycle after the last word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_valid | input | N_DEV | Per-device request (valid); bit 0 is nearest the controller |
| dev_addr | input | N_DEV*ADDR_W | Per-device word address, device i at bits i*ADDR_W upward |
| dev_data | input | N_DEV*DATA_W | Per-device data word, device i at bits i*DATA_W upward |
| dev_ready | output | N_DEV | Per-device acknowledge; the word is taken in this cycle |
| mem_valid | output | 1 | Memory write word present |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_src | output | SRC_W | Index of the device that supplied the current word |
| mem_ready | input | 1 | Memory cycle done; completes the current word |

## Verification
Every one of the 16 request masks of a four-device chain is applied from a clean start and held for two full passes. The sequence of grants must follow the set bits in ascending order and restart at the lowest one. That separates a correct scan from fixed priority, which would repeat the lowest bit, and from a scan that never wraps, which would stick on the highest bit. A stalled memory with two requesters shows that the word is held and that the next grant arrives in the very cycle the stall ends. A mask in which device 0 drops for one cycle and comes back tells the re-request precedence apart from a plain round-robin pointer, which would serve device 3 first.

// File: rtl/dca_pkg.sv
package dca_pkg;
  // Width of a device index for a chain of n devices (at least one bit).
  function automatic int src_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dca_link.sv
// One cell of the grant chain: keeps the grant for its own device or
// forwards it downstream. A cell served in the current pass skips while
// anything further down the chain is still asking.
module dca_link (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_in,
  input  logic req,
  input  logic down_req,
  input  logic commit,
  input  logic wrap,
  output logic gnt_out,
  output logic take
);
  logic skip_q;

  assign take    = gnt_in && req && !(skip_q && down_req);
  assign gnt_out = gnt_in && !take;

  always_ff @(posedge clk) begin
    if (!rst_n)                skip_q <= 1'b0;
    else if (!req)             skip_q <= 1'b0;
    else if (commit && take)   skip_q <= !wrap;
    else if (commit && wrap)   skip_q <= 1'b0;
  end

  // A dropped request always leaves the cell free to win (R6).
  assert_skip_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!skip_q || req));
endmodule

// File: rtl/dca_ctrl.sv
// Central controller: issues the chain grant when the memory port is open
// and holds one word on the port per memory cycle.
module dca_ctrl #(
  parameter int N_DEV  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     any_req,
  input  logic [N_DEV-1:0]         take,
  input  logic [N_DEV*ADDR_W-1:0]  dev_addr,
  input  logic [N_DEV*DATA_W-1:0]  dev_data,
  input  logic                     mem_ready,
  output logic                     grant_root,
  output logic                     mem_valid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_data,
  output logic [SRC_W-1:0]         mem_src
);
  logic              busy_q;
  logic              port_open;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;
  logic [SRC_W-1:0]  sel_src;

  assign port_open  = !busy_q || mem_ready;
  assign grant_root = port_open && any_req;
  assign mem_valid  = busy_q;

  always_comb begin
    sel_addr = '0;
    sel_data = '0;
    sel_src  = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (take[i]) begin
        sel_addr = sel_addr | dev_addr[i*ADDR_W +: ADDR_W];
        sel_data = sel_data | dev_data[i*DATA_W +: DATA_W];
        sel_src  = sel_src  | SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_src  <= '0;
    end else if (grant_root) begin
      busy_q   <= 1'b1;
      mem_addr <= sel_addr;
      mem_data <= sel_data;
      mem_src  <= sel_src;
    end else if (mem_ready) begin
      busy_q   <= 1'b0;
    end
  end

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_src)));

  assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (port_open && !any_req) |=> !mem_valid);
endmodule

// File: rtl/dca_arbiter.sv
module dca_arbiter
  import dca_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int SRC_W = src_width(N_DEV)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_DEV-1:0]         dev_valid,
  input  logic [N_DEV*ADDR_W-1:0]  dev_addr,
  input  logic [N_DEV*DATA_W-1:0]  dev_data,
  output logic [N_DEV-1:0]         dev_ready,
  output logic                     mem_valid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_data,
  output logic [SRC_W-1:0]         mem_src,
  input  logic                     mem_ready
);
  logic [N_DEV:0]   gnt;
  logic [N_DEV-1:0] take;
  logic [N_DEV-1:0] down_req;
  logic             any_req;
  logic             grant_root;
  logic             wrap;

  // Wired-OR request line.
  assign any_req = |dev_valid;

  // Requests strictly below each cell in the chain.
  assign down_req[N_DEV-1] = 1'b0;
  for (genvar i = 0; i < N_DEV - 1; i++) begin : g_down
    assign down_req[i] = down_req[i+1] | dev_valid[i+1];
  end

  // The winner ends the pass when nobody below it is asking.
  assign wrap = |(take & ~down_req);

  assign gnt[0] = grant_root;
  for (genvar i = 0; i < N_DEV; i++) begin : g_link
    dca_link u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_in   (gnt[i]),
      .req      (dev_valid[i]),
      .down_req (down_req[i]),
      .commit   (grant_root),
      .wrap     (wrap),
      .gnt_out  (gnt[i+1]),
      .take     (take[i])
    );
  end

  assign dev_ready = take;

  dca_ctrl #(
    .N_DEV  (N_DEV),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req    (any_req),
    .take       (take),
    .dev_addr   (dev_addr),
    .dev_data   (dev_data),
    .mem_ready  (mem_ready),
    .grant_root (grant_root),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_src    (mem_src)
  );

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_valid) && (!mem_valid || mem_ready)) |-> ($countones(dev_ready) == 1));

  assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ready) && ((dev_ready & ~dev_valid) == '0));

  assert_stall_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> (dev_ready == '0));

  assert_word_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ready) |=> mem_valid);

  assert_rerequest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!mem_valid || mem_ready) && dev_valid[0] && !$past(dev_valid[0])) |-> dev_ready[0]);
endmodule

// File: tb/dca_arbiter_tb.sv
module dca_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    dev_valid = '0;
  logic [N*AW-1:0] dev_addr;
  logic [N*DW-1:0] dev_data;
  logic [N-1:0]    dev_ready;
  logic            mem_valid;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_data;
  logic [1:0]      mem_src;
  logic            mem_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dca_arbiter #(.N_DEV(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid), .dev_addr(dev_addr),
    .dev_data(dev_data), .dev_ready(dev_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_src(mem_src),
    .mem_ready(mem_ready));

  function automatic logic [DW-1:0] word_of(input int i);
    return 16'hC03C | DW'(i << 8);
  endfunction
  function automatic logic [AW-1:0] addr_of(input int i);
    return 8'h40 + AW'(i);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      dev_data[i*DW +: DW] = word_of(i);
      dev_addr[i*AW +: AW] = addr_of(i);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Checks the word on the memory port against device i (R4).
  task automatic check_word(input int i, input string req);
    check(mem_valid == 1'b1, req, int'(mem_valid), 1);
    check(int'(mem_src) == i, req, int'(mem_src), i);
    check(mem_data == word_of(i), req, int'(mem_data), int'(word_of(i)));
    check(mem_addr == addr_of(i), req, int'(mem_addr), int'(addr_of(i)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    finish_run();
  end

  initial begin
    int idx[N];
    int pop;
    int steps[6];
    int wins[6];

    // R1: reset state
    repeat (3) @(negedge clk);
    check(mem_valid == 1'b0, "R1", int'(mem_valid), 0);
    check(dev_ready == '0, "R1", int'(dev_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_valid == 1'b0, "R1", int'(mem_valid), 0);
    check(dev_ready == '0, "R1", int'(dev_ready), 0);

    // Sweep all request masks with an always-ready memory: R3, R4, R5, R8, R9.
    mem_ready = 1'b1;
    for (int m = 0; m < (1 << N); m++) begin
      pop = 0;
      for (int b = 0; b < N; b++) if (m[b]) begin idx[pop] = b; pop++; end
      dev_valid = N'(m);
      if (pop == 0) begin
        for (int k = 0; k < 3; k++) begin
          #1;
          check(dev_ready == '0, "R9", int'(dev_ready), 0);
          @(negedge clk);
          check(mem_valid == 1'b0, "R9", int'(mem_valid), 0);
        end
      end else begin
        for (int k = 0; k < 2 * pop; k++) begin
          #1;
          // first grant of a clean pass is the lowest set bit (R3); later
          // grants walk the set bits upward and restart (R5, R8)
          if (k == 0)
            check(dev_ready == N'(1 << idx[0]), "R3", int'(dev_ready), 1 << idx[0]);
          else
            check(dev_ready == N'(1 << idx[k % pop]), "R5", int'(dev_ready), 1 << idx[k % pop]);
          @(negedge clk);
          check_word(idx[k % pop], "R4");
        end
        dev_valid = '0;
        #1;
        check(dev_ready == '0, "R9", int'(dev_ready), 0);
        @(negedge clk);
        check(mem_valid == 1'b0, "R9", int'(mem_valid), 0);
      end
    end

    // Stalled memory: R7 hold, R8 grant in the completing cycle.
    mem_ready = 1'b0;
    dev_valid = 4'b0110;
    #1;
    check(dev_ready == 4'b0010, "R3", int'(dev_ready), 2);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check_word(1, "R7");
      check(dev_ready == '0, "R7", int'(dev_ready), 0);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    #1;
    check(dev_ready == 4'b0100, "R8", int'(dev_ready), 4);
    @(negedge clk);
    check_word(2, "R8");
    dev_valid = '0;
    @(negedge clk);
    check(mem_valid == 1'b0, "R9", int'(mem_valid), 0);

    // Re-request precedence: R6.
    steps = '{4'b1111, 4'b1111, 4'b1110, 4'b1111, 4'b1111, 4'b1111};
    wins  = '{0, 1, 2, 0, 3, 0};
    for (int k = 0; k < 6; k++) begin
      dev_valid = N'(steps[k]);
      #1;
      check(dev_ready == N'(1 << wins[k]), "R6", int'(dev_ready), 1 << wins[k]);
      @(negedge clk);
      check_word(wins[k], "R6");
    end
    dev_valid = '0;
    @(negedge clk);
    check(mem_valid == 1'b0, "R9", int'(mem_valid), 0);

    finish_run();
  end
endmodule